// File: doc/BRIEF.md
# Packed SIMD Minimum/Maximum Unit

The unit takes two 128-bit packed vectors and returns, for each element position, the smaller or the larger of the two elements. The elements are 8, 16 or 32 bits wide and are compared either as two's-complement or as unsigned numbers. A second mode folds neighbouring elements together. Each pair of adjacent elements in the low 64 bits of an operand is reduced to one element. The reductions from the first operand fill the lower half of a 64-bit result, and those from the second operand fill the upper half.

Every accepted operation appears on the registered outputs one clock after the input strobe. An unsupported width code still produces a result, but that result is forced to zero and carries an error flag. The result holds its value while no new operation is presented, so a consumer may sample it late.

Top module: `simd_minmax_unit`

## Requirements
- R1: `elem_size` selects the element width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits.
- R2: `sel_min` = 1 returns the minimum of each compared pair; `sel_min` = 0 returns the maximum.
- R3: In lane-wise mode (`pairwise` = 0), every result element k is the chosen extreme of `op_a` element k and `op_b` element k across all 128 bits, giving 16, 8 or 4 lanes.
- R4: `is_signed` = 1 compares elements as two's-complement values; `is_signed` = 0 compares them as unsigned values.
- R5: In pairwise mode, with H = 32/width, result element j (j < H) is op(A[2j], A[2j+1]) and result element H+j is op(B[2j], B[2j+1]). Bits 127:64 of both operands have no effect.
- R6: In pairwise mode, result bits 127:64 are zero.
- R7: Element 0 occupies the least significant bits of each operand and of the result, and element k occupies bits k*width upward.
- R8: With `elem_size` = 3, the accepted operation produces `size_err` = 1 together with `out_valid`, and the result is zero. `size_err` is 0 for every other cycle.
- R9: `out_valid` equals the `in_valid` of the previous cycle. `result` updates one cycle after an accepted operation and holds its value while `in_valid` is low.
- R10: A synchronous active-low `rst_n` clears `out_valid`, `size_err` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 128 | First packed operand |
| op_b | input | 128 | Second packed operand |
| elem_size | input | 2 | Element width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| is_signed | input | 1 | 1: two's-complement compare, 0: unsigned compare |
| sel_min | input | 1 | 1: minimum, 0: maximum |
| pairwise | input | 1 | 1: adjacent-pair folding, 0: lane-wise |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 128 | Packed result |
| size_err | output | 1 | Accepted operation had an illegal width code |

## Verification
Two functions can act on the same accepted operation: the illegal-width handling and the pairwise folding. A stimulus with code 3 and `pairwise` set must give an all-zero result with the error flag raised. The zeroing of the upper half must not leave stale lower-half data behind. The bench also raises reset while a strobe is present, and the clearing must take priority over the capture. Each output is compared on every cycle against a behavioural model that also runs random operands through every combination of width, signedness, mode and select. Random gaps in the strobe are inserted to exercise the hold behaviour.

// File: rtl/pmm_pkg.sv
// Shared constants and types for the packed min/max unit.
// Assumes a 128-bit vector split in two halves for the pairwise mode.
package pmm_pkg;
    localparam int VEC_W     = 128;
    localparam int HALF_W    = VEC_W / 2;
    localparam int NUM_WIDTH = 3;

    typedef enum logic [1:0] {
        ESZ_8   = 2'd0,
        ESZ_16  = 2'd1,
        ESZ_32  = 2'd2,
        ESZ_BAD = 2'd3
    } esz_t;

    // Element width in bits for width index idx (0 -> 8, 1 -> 16, 2 -> 32).
    function automatic int elem_bits(input int idx);
        return 8 << idx;
    endfunction
endpackage

// File: rtl/pmm_elem_op.sv
// One element comparator: returns the minimum or maximum of x and y.
// Assumes x and y share a width; on a tie either operand is a valid answer.
module pmm_elem_op #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         is_signed,
    input  logic         sel_min,
    output logic [W-1:0] z
);
    logic x_below_y;

    // Order test in the requested number interpretation.
    always_comb begin
        if (is_signed) x_below_y = $signed(x) < $signed(y);
        else           x_below_y = x < y;
    end

    // Pick the smaller or the larger operand.
    always_comb begin
        if (sel_min) z = x_below_y ? x : y;
        else         z = x_below_y ? y : x;
    end
endmodule

// File: rtl/pmm_width_slice.sv
// All comparators for one element width: full-vector lane-wise results
// and the half-width pairwise fold. Assumes W divides 32.
module pmm_width_slice #(
    parameter int VW = 128,
    parameter int W  = 8
) (
    input  logic [VW-1:0]   a,
    input  logic [VW-1:0]   b,
    input  logic            is_signed,
    input  logic            sel_min,
    output logic [VW-1:0]   lane_z,
    output logic [VW/2-1:0] pair_z
);
    localparam int LANES = VW / W;
    localparam int HPAIR = VW / (4 * W);

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            pmm_elem_op #(.W(W)) u_lane (
                .x(a[i*W +: W]), .y(b[i*W +: W]),
                .is_signed(is_signed), .sel_min(sel_min),
                .z(lane_z[i*W +: W])
            );
        end
        for (i = 0; i < HPAIR; i++) begin : g_pair
            pmm_elem_op #(.W(W)) u_pair_a (
                .x(a[(2*i)*W +: W]), .y(a[(2*i+1)*W +: W]),
                .is_signed(is_signed), .sel_min(sel_min),
                .z(pair_z[i*W +: W])
            );
            pmm_elem_op #(.W(W)) u_pair_b (
                .x(b[(2*i)*W +: W]), .y(b[(2*i+1)*W +: W]),
                .is_signed(is_signed), .sel_min(sel_min),
                .z(pair_z[(HPAIR+i)*W +: W])
            );
        end
    endgenerate
endmodule

// File: rtl/simd_minmax_unit.sv
// Packed min/max unit top. Builds one comparator slice per element width,
// selects by width code and mode, and registers result, valid and error.
// Assumes a synchronous active-low reset and one operation per strobe.
module simd_minmax_unit
    import pmm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    input  logic [1:0]       elem_size,
    input  logic             is_signed,
    input  logic             sel_min,
    input  logic             pairwise,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             size_err
);
    logic [VEC_W-1:0]  lane_res [NUM_WIDTH];
    logic [HALF_W-1:0] pair_res [NUM_WIDTH];
    logic [VEC_W-1:0]  next_res;
    logic              bad_size;

    genvar s;
    generate
        for (s = 0; s < NUM_WIDTH; s++) begin : g_width
            pmm_width_slice #(.VW(VEC_W), .W(elem_bits(s))) u_slice (
                .a(op_a), .b(op_b),
                .is_signed(is_signed), .sel_min(sel_min),
                .lane_z(lane_res[s]), .pair_z(pair_res[s])
            );
        end
    endgenerate

    // Choose the slice output for the requested width and mode.
    always_comb begin
        bad_size = (esz_t'(elem_size) == ESZ_BAD);
        next_res = '0;
        if (!bad_size) begin
            if (pairwise) next_res = {{HALF_W{1'b0}}, pair_res[elem_size]};
            else          next_res = lane_res[elem_size];
        end
    end

    // Output register: capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            size_err  <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            size_err  <= in_valid && bad_size;
            if (in_valid) result <= next_res;
        end
    end

    // R9: valid is the strobe delayed by one cycle
    a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: result holds without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R8: error flag comes with valid and a zero result
    a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (out_valid && result == '0));
    // R6: pairwise leaves the upper half zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pairwise) |=> (result[VEC_W-1:HALF_W] == '0));
    // R10: reset clears the outputs
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !size_err && result == '0));
endmodule

// File: tb/test_simd_minmax_unit.sv
module test_simd_minmax_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0, op_b = '0;
    logic [1:0]   elem_size = 2'd0;
    logic         is_signed = 1'b0, sel_min = 1'b0, pairwise = 1'b0;
    logic         out_valid, size_err;
    logic [127:0] result;

    int checks = 0, errors = 0;
    logic         m_valid = 1'b0, m_err = 1'b0;
    logic [127:0] m_res = '0;

    always #4 clk = ~clk;

    simd_minmax_unit i_simd_minmax_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .elem_size(elem_size),
        .is_signed(is_signed), .sel_min(sel_min), .pairwise(pairwise),
        .out_valid(out_valid), .result(result), .size_err(size_err)
    );

    function automatic longint get_el(input logic [127:0] v, input int i, input int w);
        logic [127:0] t;
        t = (v >> (i * w)) & ((128'd1 << w) - 128'd1);
        return longint'(t[63:0]);
    endfunction

    function automatic longint pick(input longint x, input longint y, input logic sg,
                                    input logic mn, input int w);
        longint sx, sy;
        sx = x; sy = y;
        if (sg) begin
            if (x >= (64'sd1 <<< (w - 1))) sx = x - (64'sd1 <<< w);
            if (y >= (64'sd1 <<< (w - 1))) sy = y - (64'sd1 <<< w);
        end
        if (mn) return (sx < sy) ? x : y;
        return (sx < sy) ? y : x;
    endfunction

    function automatic logic [127:0] put_el(input logic [127:0] r, input int i,
                                            input int w, input longint v);
        logic [127:0] t;
        t = '0;
        t[63:0] = v;
        return r | (t << (i * w));
    endfunction

    function automatic logic [127:0] ref_calc(input logic [127:0] a, input logic [127:0] b,
            input logic [1:0] sz, input logic sg, input logic mn, input logic pw);
        logic [127:0] r;
        int w, n, h;
        r = '0;
        if (sz == 2'd3) return r;
        w = 8 << sz; n = 128 / w; h = 32 / w;
        if (!pw) begin
            for (int i = 0; i < n; i++)
                r = put_el(r, i, w, pick(get_el(a, i, w), get_el(b, i, w), sg, mn, w));
        end else begin
            for (int j = 0; j < h; j++) begin
                r = put_el(r, j, w, pick(get_el(a, 2*j, w), get_el(a, 2*j+1, w), sg, mn, w));
                r = put_el(r, h + j, w, pick(get_el(b, 2*j, w), get_el(b, 2*j+1, w), sg, mn, w));
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag);
        checks++;
        if (out_valid !== m_valid || size_err !== m_err || result !== m_res) begin
            errors++;
            $display("FAIL %s: actual v=%b e=%b r=%h expected v=%b e=%b r=%h",
                     tag, out_valid, size_err, result, m_valid, m_err, m_res);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, update the model at the
    // rising edge and compare shortly after it.
    task automatic step(input string tag, input logic rn, input logic iv,
                        input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                        input logic sg, input logic mn, input logic pw);
        rst_n = rn; in_valid = iv; op_a = a; op_b = b; elem_size = sz;
        is_signed = sg; sel_min = mn; pairwise = pw;
        @(posedge clk);
        if (!rn) begin
            m_valid = 1'b0; m_err = 1'b0; m_res = '0;
        end else begin
            m_valid = iv;
            m_err = iv && (sz == 2'd3);
            if (iv) m_res = ref_calc(a, b, sz, sg, mn, pw);
        end
        #2;
        chk(tag);
        @(negedge clk);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] held;
        @(negedge clk);
        // R10: reset state
        step("R10 reset", 1'b0, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
        step("R10 reset", 1'b0, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
        // R7 R1: lane 0 is the low byte, 8-bit width
        step("R7 lsb lane", 1'b1, 1'b1, 128'h01, 128'h02, 2'd0, 1'b0, 1'b0, 1'b0);
        step("R1 width16", 1'b1, 1'b1, 128'h00ff_0001, 128'h0100_0000, 2'd1, 1'b0, 1'b0, 1'b0);
        step("R1 width32", 1'b1, 1'b1, {4{32'h8000_0000}}, {4{32'h7fff_ffff}}, 2'd2, 1'b0, 1'b1, 1'b0);
        // R4: signed versus unsigned on the sign bit
        step("R4 signed", 1'b1, 1'b1, {16{8'h80}}, {16{8'h01}}, 2'd0, 1'b1, 1'b0, 1'b0);
        step("R4 unsigned", 1'b1, 1'b1, {16{8'h80}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b0);
        // R2: min against max on the same data
        step("R2 min", 1'b1, 1'b1, {8{16'h1234}}, {8{16'hfedc}}, 2'd1, 1'b1, 1'b1, 1'b0);
        step("R2 max", 1'b1, 1'b1, {8{16'h1234}}, {8{16'hfedc}}, 2'd1, 1'b1, 1'b0, 1'b0);
        // R3: all lanes differ
        step("R3 lanes", 1'b1, 1'b1, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0,
             128'hf0e1d2c3b4a5968778695a4b3c2d1e0f, 2'd0, 1'b0, 1'b1, 1'b0);
        // R5 R6: pairwise with junk in the upper halves
        step("R5 pair8", 1'b1, 1'b1, {64'hdeadbeefdeadbeef, 64'h0807060504030201},
             {64'hcafef00dcafef00d, 64'h1011121314151617}, 2'd0, 1'b0, 1'b0, 1'b1);
        step("R6 pair32", 1'b1, 1'b1, {64'hffffffffffffffff, 64'h00000005_fffffffb},
             {64'h1234567812345678, 64'h80000000_00000001}, 2'd2, 1'b1, 1'b1, 1'b1);
        // R8: illegal width, lane-wise and together with pairwise
        step("R8 bad size", 1'b1, 1'b1, rnd128(), rnd128(), 2'd3, 1'b0, 1'b0, 1'b0);
        step("R8 bad pair", 1'b1, 1'b1, rnd128(), rnd128(), 2'd3, 1'b1, 1'b1, 1'b1);
        // R9: hold without strobe; error clears
        step("R9 capture", 1'b1, 1'b1, rnd128(), rnd128(), 2'd1, 1'b1, 1'b0, 1'b0);
        held = result;
        step("R9 hold", 1'b1, 1'b0, rnd128(), rnd128(), 2'd3, 1'b1, 1'b1, 1'b1);
        checks++;
        if (result !== held) begin
            errors++;
            $display("FAIL R9 hold: actual=%h expected=%h", result, held);
        end
        // R10: reset wins over a strobe in the same cycle
        step("R10 reset with strobe", 1'b0, 1'b1, rnd128(), rnd128(), 2'd0, 1'b0, 1'b0, 1'b0);
        // Random sweep across all combinations
        for (int sz = 0; sz < 4; sz++)
            for (int c = 0; c < 8; c++)
                for (int k = 0; k < 20; k++) begin
                    logic iv;
                    iv = ($urandom % 5) != 0;
                    step(c[2] ? "R5 random pairwise" : "R3 random lanes", 1'b1, iv,
                         rnd128(), rnd128(), sz[1:0], c[0], c[1], c[2]);
                end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule